// File: doc/BRIEF.md
# Video Floating Bus Read Logic

This block produces the byte a video controller leaves on the CPU data bus when the CPU reads an I/O port that no peripheral drives. The value depends on where the raster is. While the beam crosses the paper area, the video fetch sequencer places bitmap and attribute bytes on the bus at fixed T states. At other times the bus carries an idle value. Software uses this to lock onto the raster at single-T-state precision by placing unique marker codes in video memory.

One clock equals one T state. An external raster counter supplies the T state within the line and the line number. The fetch sequencer supplies the byte it fetches in each T state. The block has three machine behaviours, selected by a configuration input that is sampled only while reset is high.

- **Classic:** a bitmap/attribute pattern with a fixed 0xFF idle value.
- **Late-model:** port-decoded. Bit 0 is forced high, and idle values come from the latest attribute or from a latched contended-memory access.
- **Attribute-only:** each attribute is held for four T states.

Top module: `fbus_read_logic`

## Requirements
- R1: After reset `rd_data` is 0xFF and `rd_ack` is 0. The mode is taken from `mode_sel` only while `rst` is high, and later changes of `mode_sel` have no effect.
- R2: Classic mode, paper area. Let o = T state minus the paper start. For o mod 8 equal to 0 or 2 (bitmap) and 1 or 3 (attribute), the read returns the `vid_data` present in that T state. For o mod 8 from 4 to 7 it returns 0xFF.
- R3: In classic and attribute-only modes, a read outside the paper area returns 0xFF. The paper area is T states [PAPER_T0, PAPER_T0+PAPER_LEN) on lines [PAPER_LINE0, PAPER_LINE0+PAPER_LINES).
- R4: In late-model mode the block answers only when `en_128k` is 1 and (`io_addr` & 0xF003) equals 0x0001. Classic and attribute-only modes answer every read. When the block does not answer, `rd_ack` stays 0 and `rd_data` keeps its previous value.
- R5: In late-model mode, bit 0 of every returned byte is 1.
- R6: Late-model mode, paper area. Slots 0 to 3 return `vid_data` as in classic mode. Slots 4 to 7 return the most recent attribute, so a group reads B0 A0 B1 A1 A1 A1 A1 A1.
- R7: In late-model mode, a border read with no latched access returns the most recent attribute fetched. That is the last attribute of the line, or 0xFF if no attribute has been fetched since reset.
- R8: In late-model mode, a memory access (`mem_acc`) during border time latches `mem_data` as the border value. The latch holds until the raster next enters the paper area. Accesses made over the paper area are ignored.
- R9: Attribute-only mode, paper area. When o mod 4 is 0 the read returns `vid_data`, which is the attribute. When o mod 4 is 1, 2 or 3 it returns the attribute captured at the start of that 4-T-state slot.
- R10: Each read strobe gives exactly one result. It is registered, and it appears in `rd_data` with `rd_ack` high in the cycle after the strobe.
- R11: Mode encoding: 0 is classic, 1 is late-model, 2 is attribute-only, and 3 behaves as classic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst | input | 1 | Synchronous active-high reset; mode sampled while high |
| mode_sel | input | 2 | Mode configuration (see R11) |
| en_128k | input | 1 | Port decode enable for late-model mode |
| ras_t | input | TW | T state within the line |
| ras_line | input | LW | Line number in the frame |
| vid_data | input | 8 | Byte fetched by the video sequencer this T state |
| io_addr | input | 16 | I/O port address |
| io_rd | input | 1 | I/O read strobe, one per read |
| mem_acc | input | 1 | CPU contended-memory access this T state |
| mem_data | input | 8 | Data of that memory access |
| rd_data | output | 8 | Returned bus byte |
| rd_ack | output | 1 | Block answered the read of the previous cycle |

## Verification
Every mode sweeps whole lines: one line above the paper, the first and second paper rows, the last paper row and one line below. This covers the border/paper boundary in both T and line. On the first paper row every T state is read, so each fetch-pattern offset is seen. `vid_data` carries a code that is unique within the line, so a value returned from the wrong slot, or a stale held value, is distinguishable from the correct one. Random port addresses, random `en_128k` and random contended accesses over both border and paper exercise the late-model decode, the border latch and its clearing at paper entry.

// File: rtl/fbus_pkg.sv
package fbus_pkg;
  typedef enum logic [1:0] {
    FB_CLASSIC = 2'd0,
    FB_LATE    = 2'd1,
    FB_ATTR    = 2'd2,
    FB_ALT     = 2'd3
  } fb_mode_e;

  function automatic fb_mode_e fb_decode(input logic [1:0] sel);
    case (sel)
      2'd1:    return FB_LATE;
      2'd2:    return FB_ATTR;
      default: return FB_CLASSIC;
    endcase
  endfunction
endpackage

// File: rtl/fbus_raster_decode.sv
module fbus_raster_decode #(
  parameter int TW          = 8,
  parameter int LW          = 9,
  parameter int PAPER_T0    = 0,
  parameter int PAPER_LEN   = 128,
  parameter int PAPER_LINE0 = 64,
  parameter int PAPER_LINES = 192
) (
  input  logic [TW-1:0] ras_t,
  input  logic [LW-1:0] ras_line,
  output logic          in_paper,
  output logic [2:0]    slot
);
  localparam logic [TW-1:0] T_LO = TW'(PAPER_T0);
  localparam logic [TW:0]   T_HI = (TW+1)'(PAPER_T0 + PAPER_LEN);
  localparam logic [LW-1:0] L_LO = LW'(PAPER_LINE0);
  localparam logic [LW:0]   L_HI = (LW+1)'(PAPER_LINE0 + PAPER_LINES);

  logic t_in, l_in;
  always_comb begin
    t_in     = (ras_t >= T_LO) && ({1'b0, ras_t} < T_HI);
    l_in     = (ras_line >= L_LO) && ({1'b0, ras_line} < L_HI);
    in_paper = t_in && l_in;
    slot     = 3'(ras_t - T_LO);
  end
endmodule

// File: rtl/fbus_attr_hold.sv
module fbus_attr_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          late,
  input  logic          in_paper,
  input  logic          attr_strobe,
  input  logic [DW-1:0] vid_data,
  input  logic          mem_acc,
  input  logic [DW-1:0] mem_data,
  output logic [DW-1:0] last_attr,
  output logic [DW-1:0] border_val
);
  logic          ovr;
  logic [DW-1:0] ovr_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_attr <= '1;
      ovr       <= 1'b0;
      ovr_val   <= '1;
    end else begin
      if (attr_strobe) last_attr <= vid_data;
      if (in_paper) begin
        ovr <= 1'b0;
      end else if (late && mem_acc) begin
        ovr     <= 1'b1;
        ovr_val <= mem_data;
      end
    end
  end

  assign border_val = ovr ? ovr_val : last_attr;
endmodule

// File: rtl/fbus_slot_select.sv
module fbus_slot_select
  import fbus_pkg::*;
#(
  parameter int DW = 8
) (
  input  fb_mode_e      mode,
  input  logic          in_paper,
  input  logic [2:0]    slot,
  input  logic [DW-1:0] vid_data,
  input  logic [DW-1:0] last_attr,
  input  logic [DW-1:0] border_val,
  output logic          attr_strobe,
  output logic [DW-1:0] value
);
  localparam logic [DW-1:0] IDLE = '1;

  always_comb begin
    value       = IDLE;
    attr_strobe = 1'b0;
    case (mode)
      FB_LATE: begin
        attr_strobe = in_paper && !slot[2] && slot[0];
        if (in_paper) value = slot[2] ? last_attr : vid_data;
        else          value = border_val;
        value[0] = 1'b1;
      end
      FB_ATTR: begin
        attr_strobe = in_paper && (slot[1:0] == 2'd0);
        if (in_paper) value = (slot[1:0] == 2'd0) ? vid_data : last_attr;
      end
      default: begin
        if (in_paper && !slot[2]) value = vid_data;
      end
    endcase
  end
endmodule

// File: rtl/fbus_port_gate.sv
module fbus_port_gate
  import fbus_pkg::*;
#(
  parameter int          AW         = 16,
  parameter logic [15:0] PORT_MASK  = 16'hF003,
  parameter logic [15:0] PORT_MATCH = 16'h0001
) (
  input  fb_mode_e      mode,
  input  logic          en_128k,
  input  logic [AW-1:0] io_addr,
  input  logic          io_rd,
  output logic          answer
);
  localparam logic [AW-1:0] MSK = AW'(PORT_MASK);
  localparam logic [AW-1:0] MAT = AW'(PORT_MATCH);

  always_comb begin
    if (mode == FB_LATE) answer = io_rd && en_128k && ((io_addr & MSK) == MAT);
    else                 answer = io_rd;
  end
endmodule

// File: rtl/fbus_read_logic.sv
module fbus_read_logic
  import fbus_pkg::*;
#(
  parameter int LINE_T      = 224,
  parameter int FRAME_LINES = 312,
  parameter int PAPER_T0    = 0,
  parameter int PAPER_LEN   = 128,
  parameter int PAPER_LINE0 = 64,
  parameter int PAPER_LINES = 192,
  parameter int DW          = 8,
  parameter int AW          = 16,
  parameter int TW          = $clog2(LINE_T),
  parameter int LW          = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_sel,
  input  logic          en_128k,
  input  logic [TW-1:0] ras_t,
  input  logic [LW-1:0] ras_line,
  input  logic [DW-1:0] vid_data,
  input  logic [AW-1:0] io_addr,
  input  logic          io_rd,
  input  logic          mem_acc,
  input  logic [DW-1:0] mem_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_ack
);
  fb_mode_e      mode_q;
  logic          in_paper, attr_strobe, answer;
  logic [2:0]    slot;
  logic [DW-1:0] last_attr, border_val, value;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= fb_decode(mode_sel);
  end

  fbus_raster_decode #(
    .TW(TW), .LW(LW), .PAPER_T0(PAPER_T0), .PAPER_LEN(PAPER_LEN),
    .PAPER_LINE0(PAPER_LINE0), .PAPER_LINES(PAPER_LINES)
  ) u_dec (
    .ras_t(ras_t), .ras_line(ras_line), .in_paper(in_paper), .slot(slot)
  );

  fbus_slot_select #(.DW(DW)) u_sel (
    .mode(mode_q), .in_paper(in_paper), .slot(slot), .vid_data(vid_data),
    .last_attr(last_attr), .border_val(border_val),
    .attr_strobe(attr_strobe), .value(value)
  );

  fbus_attr_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .late(mode_q == FB_LATE), .in_paper(in_paper),
    .attr_strobe(attr_strobe), .vid_data(vid_data), .mem_acc(mem_acc),
    .mem_data(mem_data), .last_attr(last_attr), .border_val(border_val)
  );

  fbus_port_gate #(.AW(AW)) u_gate (
    .mode(mode_q), .en_128k(en_128k), .io_addr(io_addr), .io_rd(io_rd),
    .answer(answer)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '1;
      rd_ack  <= 1'b0;
    end else begin
      rd_ack <= answer;
      if (answer) rd_data <= value;
    end
  end
endmodule

// File: rtl/fbus_read_logic_chk.sv
module fbus_read_logic_chk (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  mode_q,
  input logic        io_rd,
  input logic [15:0] io_addr,
  input logic        en_128k,
  input logic        in_paper,
  input logic        rd_ack,
  input logic [7:0]  rd_data
);
  assert_ack_after_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    rd_ack |-> $past(io_rd));

  assert_data_held_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_ack |-> $stable(rd_data));

  assert_late_port_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && mode_q == 2'd1) |-> ($past(en_128k) && (($past(io_addr) & 16'hF003) == 16'h0001)));

  assert_late_bit0_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && mode_q == 2'd1) |-> rd_data[0]);

  assert_border_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && mode_q != 2'd1 && !$past(in_paper)) |-> rd_data == 8'hFF);
endmodule

bind fbus_read_logic fbus_read_logic_chk u_chk (
  .clk(clk), .rst(rst), .mode_q(mode_q), .io_rd(io_rd), .io_addr(io_addr),
  .en_128k(en_128k), .in_paper(in_paper), .rd_ack(rd_ack), .rd_data(rd_data)
);

// File: tb/fbus_read_logic_test.sv
module fbus_read_logic_test;
  localparam int LINE_T = 224;
  localparam int PT0 = 0, PLEN = 128, PL0 = 64, PLINES = 192;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'd0;
  logic       en_128k = 1'b1;
  logic [7:0] ras_t = '0;
  logic [8:0] ras_line = '0;
  logic [7:0] vid_data = '0;
  logic [15:0] io_addr = '0;
  logic       io_rd = 1'b0;
  logic       mem_acc = 1'b0;
  logic [7:0] mem_data = '0;
  logic [7:0] rd_data;
  logic       rd_ack;

  int n_cmp = 0, n_bad = 0;

  // bench model state
  int         m_mode;
  logic [7:0] m_last, m_oval, prev_data;
  logic       m_ovr;
  logic       p_valid, p_ans;
  logic [7:0] p_exp;
  string      p_req;

  always #5 clk = ~clk;

  fbus_read_logic uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .en_128k(en_128k),
    .ras_t(ras_t), .ras_line(ras_line), .vid_data(vid_data),
    .io_addr(io_addr), .io_rd(io_rd), .mem_acc(mem_acc), .mem_data(mem_data),
    .rd_data(rd_data), .rd_ack(rd_ack)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [7:0] code(int line, int t);
    return 8'(t) ^ {line[2:0], 5'h0A};
  endfunction

  task automatic check_pending();
    if (p_valid) begin
      check("R10 ack", {7'd0, rd_ack}, {7'd0, p_ans});
      if (p_ans) begin
        check(p_req, rd_data, p_exp);
        if (m_mode == 1) check("R5 bit0", {7'd0, rd_data[0]}, 8'd1);
      end else begin
        check("R4 data unchanged", rd_data, prev_data);
      end
      prev_data = rd_data;
    end
  endtask

  task automatic step(int line, int t, bit force_rd);
    logic       pap, ans, strobe;
    logic [2:0] sl;
    logic [7:0] exp;
    string      req;
    @(negedge clk);
    check_pending();
    ras_line = 9'(line);
    ras_t    = 8'(t);
    vid_data = code(line, t);
    io_rd    = force_rd || ($urandom % 4 != 0);
    en_128k  = ($urandom % 8 != 0);
    io_addr  = ($urandom % 2 == 0) ? ((16'($urandom) & 16'h0FFC) | 16'h0001) : 16'($urandom);
    mem_acc  = ($urandom % 5 == 0);
    mem_data = 8'($urandom);
    pap = (t >= PT0) && (t < PT0 + PLEN) && (line >= PL0) && (line < PL0 + PLINES);
    sl  = 3'(t - PT0);
    strobe = 1'b0;
    if (m_mode == 1) begin
      ans = io_rd && en_128k && ((io_addr & 16'hF003) == 16'h0001);
      if (pap) begin
        strobe = !sl[2] && sl[0];
        exp = sl[2] ? m_last : vid_data;
        req = sl[2] ? "R6 late idle slot" : "R6 late fetch slot";
      end else begin
        exp = m_ovr ? m_oval : m_last;
        req = m_ovr ? "R8 latched border" : "R7 late border";
      end
      exp[0] = 1'b1;
    end else if (m_mode == 2) begin
      ans = io_rd;
      if (pap) begin
        strobe = (sl[1:0] == 2'd0);
        exp = strobe ? vid_data : m_last;
        req = "R9 attribute-only";
      end else begin
        exp = 8'hFF;
        req = "R3 border";
      end
    end else begin
      ans = io_rd;
      if (pap) begin
        exp = sl[2] ? 8'hFF : vid_data;
        req = "R2 classic pattern";
      end else begin
        exp = 8'hFF;
        req = "R3 border";
      end
    end
    p_valid = 1'b1;
    p_ans   = ans;
    p_exp   = exp;
    p_req   = req;
    if (strobe) m_last = vid_data;
    if (pap) m_ovr = 1'b0;
    else if (m_mode == 1 && mem_acc) begin
      m_ovr  = 1'b1;
      m_oval = mem_data;
    end
  endtask

  task automatic run_mode(logic [1:0] m);
    int lines[5];
    lines = '{PL0 - 1, PL0, PL0 + 1, PL0 + PLINES - 1, PL0 + PLINES};
    @(negedge clk);
    rst = 1'b1; io_rd = 1'b0; mem_acc = 1'b0; mode_sel = m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mode_sel = ~m;  // R1: ignored after reset
    @(negedge clk);
    check("R1 reset data", rd_data, 8'hFF);
    check("R1 reset ack", {7'd0, rd_ack}, 8'd0);
    m_mode = (m == 2'd3) ? 0 : int'(m);  // R11: code 3 acts as classic
    m_last = 8'hFF; m_oval = 8'hFF; m_ovr = 1'b0;
    prev_data = 8'hFF; p_valid = 1'b0;
    foreach (lines[i]) begin
      for (int t = 0; t < LINE_T; t++) step(lines[i], t, lines[i] == PL0);
    end
    @(negedge clk);
    check_pending();
    p_valid = 1'b0;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int m = 0; m < 4; m++) run_mode(2'(m));
    finish_run();
  end
endmodule